// File: doc/BRIEF.md
# Fractional PLL Control Register Bank

This block is the software-facing control bank of a fractional PLL. A plain 32-bit register bus (address, write strobe, write data, combinational read data) programs the integer divider fields, a signed fractional divider, an enable bit and a lock-time value. It drives these values straight to the PLL. It also models lock with a down-counter, so the oscillator itself stays outside the block.

Any divider update that lands while the PLL is enabled drops the lock flag on the next clock. It also starts the counter from the lock-time register, and the flag rises again when the count ends. Software is expected to program 500 reference cycles per unit of the pre-divider before it touches the dividers. A guard bit in a separate register blocks all divider writes while it is clear, so a rate change then never restarts lock.

Register map (byte addresses): lock time at 0x00, guard register at 0x04, control word at 0x10, fractional divider at 0x18. The fractional divider must sit eight bytes above the control word.

Top module: `fpll_ctrl`

## Requirements
- R1: After reset the PLL is disabled and unlocked, M, P, S, K and the lock time are zero, and the guard register reads 0x0000_0002 (guard bit 1 set).
- R2: The control word at 0x10 places M at bits 24:16, P at bits 13:8, S at bits 2:0, enable at bit 31 and the read-only lock flag at bit 29. All other bits read as zero, and writes to bit 29 have no effect.
- R3: The register at 0x18 holds K, a 16-bit two's-complement value, in bits 15:0. Its upper bits read as zero, and K drives pll_k.
- R4: The lock-time register at 0x00 keeps the low LOCK_W bits (20 by default) of a write. Its upper bits read as zero.
- R5: A control write that turns enable from 0 to 1 clears the lock flag on the next cycle. The flag is set again exactly N clock edges after the write edge, where N is the lock-time value.
- R6: Every accepted divider write while enabled restarts the lock sequence of R5. This covers a control write with enable set and any write to the fractional register, even when only S changes or the value is unchanged.
- R7: While guard bit 1 is clear, writes to M, P, S and K are ignored and do not restart lock. The enable bit stays writable, and setting it starts a lock sequence on the held dividers.
- R8: Divider writes while disabled update the fields, but the lock flag stays low and no count runs.
- R9: A control write with enable clear drops the lock flag on the next cycle and stops the counter. A later enable runs a full count.
- R10: The lock time is captured when a sequence starts, so later writes to the lock-time register do not change a running count. A lock time of zero acts as one cycle.
- R11: Reads of unmapped addresses return zero, and writes to them change nothing.
- R12: A restart during a running count reloads the full lock time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pll_en | output | 1 | PLL enable |
| pll_locked | output | 1 | Modelled lock status |
| pll_m | output | 9 | Main divider M |
| pll_p | output | 6 | Pre-divider P |
| pll_s | output | 3 | Post-divider S |
| pll_k | output | 16 | Signed fractional divider K |

## Verification
The bench measures the low window after each start edge by edge. An off-by-one counter, or a lock flag that rises early, shows up as a flag that is high one cycle too soon or too late. It changes only S, or rewrites an identical value, to catch a design that restarts lock only when a value differs. It clears the guard bit and then writes the dividers, which exposes a design that lets the fields through or drops lock on an ignored write. It also rewrites the lock time during a count, restarts mid-count and disables mid-count, to catch a counter that reads the live register, continues from a stale count, or leaves the flag stuck high after disable.

// File: rtl/fpll_pkg.sv
package fpll_pkg;
    localparam int DATA_W   = 32;

    // control word layout
    localparam int M_LSB    = 16;
    localparam int M_W      = 9;
    localparam int P_LSB    = 8;
    localparam int P_W      = 6;
    localparam int S_LSB    = 0;
    localparam int S_W      = 3;
    localparam int EN_BIT   = 31;
    localparam int LOCK_BIT = 29;

    // fractional register layout
    localparam int K_W      = 16;

    // guard register layout
    localparam int GUARD_BIT = 1;

    // byte offsets; the fractional register must sit 8 above the control word
    localparam int OFS_LOCKT = 'h00;
    localparam int OFS_GUARD = 'h04;
    localparam int OFS_CTRL  = 'h10;
    localparam int OFS_FRAC  = OFS_CTRL + 'h8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOCKT,
        SEL_GUARD,
        SEL_CTRL,
        SEL_FRAC
    } reg_sel_e;
endpackage

// File: rtl/fpll_addr_dec.sv
module fpll_addr_dec
    import fpll_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(OFS_LOCKT))      sel = SEL_LOCKT;
        else if (addr == ADDR_W'(OFS_GUARD)) sel = SEL_GUARD;
        else if (addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_FRAC))  sel = SEL_FRAC;
        else                                 sel = SEL_NONE;
    end
endmodule

// File: rtl/fpll_regfile.sv
module fpll_regfile
    import fpll_pkg::*;
#(
    parameter int LOCK_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [LOCK_W-1:0] lock_time,
    output logic              guard,
    output logic              en,
    output logic [M_W-1:0]    m,
    output logic [P_W-1:0]    p,
    output logic [S_W-1:0]    s,
    output logic [K_W-1:0]    k,
    output logic              start,
    output logic              stop
);
    typedef struct packed {
        logic [LOCK_W-1:0] lt;
        logic              guard;
        logic              en;
        logic [M_W-1:0]    m;
        logic [P_W-1:0]    p;
        logic [S_W-1:0]    s;
        logic [K_W-1:0]    k;
    } regs_t;

    regs_t r_d, r_q;
    logic  start_d, stop_d;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        r_d     = r_q;
        start_d = 1'b0;
        stop_d  = 1'b0;
        if (we) begin
            unique case (sel)
                SEL_LOCKT: r_d.lt    = wdata[LOCK_W-1:0];
                SEL_GUARD: r_d.guard = wdata[GUARD_BIT];
                SEL_CTRL: begin
                    r_d.en = wdata[EN_BIT];
                    if (r_q.guard) begin
                        r_d.m = wdata[M_LSB +: M_W];
                        r_d.p = wdata[P_LSB +: P_W];
                        r_d.s = wdata[S_LSB +: S_W];
                    end
                    if (!wdata[EN_BIT])
                        stop_d = 1'b1;
                    else if (!r_q.en || r_q.guard)
                        start_d = 1'b1;
                end
                SEL_FRAC: begin
                    if (r_q.guard) begin
                        r_d.k = wdata[K_W-1:0];
                        if (r_q.en)
                            start_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.guard <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign lock_time = r_q.lt;
    assign guard     = r_q.guard;
    assign en        = r_q.en;
    assign m         = r_q.m;
    assign p         = r_q.p;
    assign s         = r_q.s;
    assign k         = r_q.k;
    assign start     = start_d;
    assign stop      = stop_d;
endmodule

// File: rtl/fpll_lock_timer.sv
module fpll_lock_timer #(
    parameter int LOCK_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [LOCK_W-1:0] lock_time,
    output logic              locked
);
    typedef struct packed {
        logic [LOCK_W-1:0] cnt;
        logic              locked;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (stop) begin
            t_d.cnt    = '0;
            t_d.locked = 1'b0;
        end else if (start) begin
            t_d.cnt    = (lock_time == '0) ? LOCK_W'(1) : lock_time;
            t_d.locked = 1'b0;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - LOCK_W'(1);
            if (t_q.cnt == LOCK_W'(1))
                t_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign locked = t_q.locked;
endmodule

// File: rtl/fpll_ctrl.sv
module fpll_ctrl
    import fpll_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LOCK_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 pll_en,
    output logic                 pll_locked,
    output logic [M_W-1:0]       pll_m,
    output logic [P_W-1:0]       pll_p,
    output logic [S_W-1:0]       pll_s,
    output logic [K_W-1:0]       pll_k
);
    reg_sel_e          sel;
    logic [LOCK_W-1:0] lock_time;
    logic              guard_en;
    logic              seq_start, seq_stop;

    fpll_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    fpll_regfile #(.LOCK_W(LOCK_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .lock_time (lock_time),
        .guard     (guard_en),
        .en        (pll_en),
        .m         (pll_m),
        .p         (pll_p),
        .s         (pll_s),
        .k         (pll_k),
        .start     (seq_start),
        .stop      (seq_stop)
    );

    fpll_lock_timer #(.LOCK_W(LOCK_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .stop      (seq_stop),
        .lock_time (lock_time),
        .locked    (pll_locked)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_LOCKT: bus_rdata[LOCK_W-1:0]   = lock_time;
            SEL_GUARD: bus_rdata[GUARD_BIT]    = guard_en;
            SEL_CTRL: begin
                bus_rdata[EN_BIT]          = pll_en;
                bus_rdata[LOCK_BIT]        = pll_locked;
                bus_rdata[M_LSB +: M_W]    = pll_m;
                bus_rdata[P_LSB +: P_W]    = pll_p;
                bus_rdata[S_LSB +: S_W]    = pll_s;
            end
            SEL_FRAC:  bus_rdata[K_W-1:0]      = pll_k;
            default: ;
        endcase
    end
endmodule

// File: rtl/fpll_ctrl_chk.sv
module fpll_ctrl_chk
    import fpll_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              wr_en_bit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              guard_en,
    input logic              pll_en,
    input logic              pll_locked,
    input logic [M_W-1:0]    pll_m,
    input logic [P_W-1:0]    pll_p,
    input logic [S_W-1:0]    pll_s,
    input logic [K_W-1:0]    pll_k
);
    logic wr_ctrl, wr_frac, mapped;
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_frac = bus_we && (bus_addr == ADDR_W'(OFS_FRAC));
    assign mapped  = (bus_addr == ADDR_W'(OFS_LOCKT)) || (bus_addr == ADDR_W'(OFS_GUARD)) ||
                     (bus_addr == ADDR_W'(OFS_CTRL))  || (bus_addr == ADDR_W'(OFS_FRAC));

    a_r9_disable_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !wr_en_bit |=> !pll_locked && !pll_en);

    a_r5_lock_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pll_locked |-> pll_en);

    a_r7_guard_holds_int: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !guard_en |=> $stable(pll_m) && $stable(pll_p) && $stable(pll_s));

    a_r7_guard_holds_frac: assert property (@(posedge clk) disable iff (!rst_n)
        wr_frac && !guard_en |=> $stable(pll_k));

    a_r6_frac_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_frac && guard_en && pll_en |=> !pll_locked);

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);

    a_r2_lock_bit_view: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(OFS_CTRL) |-> bus_rdata[LOCK_BIT] == pll_locked);
endmodule

bind fpll_ctrl fpll_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .wr_en_bit  (bus_wdata[fpll_pkg::EN_BIT]),
    .bus_rdata  (bus_rdata),
    .guard_en   (guard_en),
    .pll_en     (pll_en),
    .pll_locked (pll_locked),
    .pll_m      (pll_m),
    .pll_p      (pll_p),
    .pll_s      (pll_s),
    .pll_k      (pll_k)
);

// File: tb/tb_fpll_ctrl.sv
module tb_fpll_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam logic [7:0] A_LT = 8'h00, A_GD = 8'h04, A_CT = 8'h10, A_FR = 8'h18;
    localparam logic [31:0] EN = 32'h8000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              pll_en, pll_locked;
    logic [8:0]        pll_m;
    logic [5:0]        pll_p;
    logic [2:0]        pll_s;
    logic [15:0]       pll_k;

    int n_chk = 0;
    int n_bad = 0;

    fpll_ctrl #(.ADDR_W(ADDR_W), .LOCK_W(20)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_en(pll_en),
        .pll_locked(pll_locked), .pll_m(pll_m), .pll_p(pll_p),
        .pll_s(pll_s), .pll_k(pll_k)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    // right after the triggering write: low now, low through lt-1 edges, high at edge lt
    task automatic wait_lock(input int lt, input string tag);
        logic early;
        early = 1'b0;
        chk({tag, " low after start"}, 32'(pll_locked), 0);
        for (int i = 1; i < lt; i++) begin
            @(posedge clk); @(negedge clk);
            if (pll_locked) early = 1'b1;
        end
        chk({tag, " no early lock"}, 32'(early), 0);
        @(posedge clk); @(negedge clk);
        chk({tag, " locked at count end"}, 32'(pll_locked), 1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_LT, v); chk("R1 lock time", v, 0);
        rd(A_GD, v); chk("R1 guard", v, 32'h2);
        rd(A_CT, v); chk("R1 ctrl", v, 0);
        rd(A_FR, v); chk("R1 frac", v, 0);
        chk("R1 outputs", {pll_en, pll_locked, pll_m, pll_p, pll_s, pll_k}, 0);
    endtask

    task automatic t_fields;
        logic [31:0] v;
        wr(A_CT, 32'h7FFF_FFFF);
        rd(A_CT, v); chk("R2 layout, bit29 ignored", v, 32'h01FF_3F07);
        chk("R2 field outputs", {pll_m, pll_p, pll_s}, {9'h1FF, 6'h3F, 3'h7});
        cycles(5);
        chk("R8 disabled no lock", {pll_en, pll_locked}, 0);
        wr(A_CT, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(A_FR, 32'hABCD_8001);
        rd(A_FR, v); chk("R3 frac readback", v, 32'h0000_8001);
        chk("R3 pll_k", 32'(pll_k), 32'h8001);
        wr(A_LT, 32'hFFFF_FFFF);
        rd(A_LT, v); chk("R4 lock time width", v, 32'h000F_FFFF);
    endtask

    task automatic t_lock_seq;
        logic [31:0] v;
        wr(A_LT, 32'd1000);
        wr(A_CT, EN | 32'h001F_0201);
        wait_lock(1000, "R5 enable");
        rd(A_CT, v); chk("R2 lock bit reads", v, 32'hA01F_0201);
        wr(A_FR, 32'h0000_C4EC);
        wait_lock(1000, "R6 frac write");
        chk("R3 signed K", 32'(pll_k), 32'hC4EC);
        wr(A_LT, 32'd5);
        wr(A_CT, EN | 32'h001F_0200);
        wait_lock(5, "R6 S only");
        wr(A_CT, EN | 32'h001F_0200);
        wait_lock(5, "R6 same value");
    endtask

    task automatic t_guard;
        logic [31:0] v;
        wr(A_GD, 32'h0);
        rd(A_GD, v); chk("R7 guard clear", v, 0);
        wr(A_CT, EN | 32'h0064_0302);
        chk("R7 ctrl ignored", {pll_m, pll_p, pll_s}, {9'd31, 6'd2, 3'd0});
        chk("R7 lock kept", 32'(pll_locked), 1);
        wr(A_FR, 32'h1);
        cycles(3);
        chk("R7 frac ignored", 32'(pll_k), 32'hC4EC);
        chk("R7 lock kept later", 32'(pll_locked), 1);
        wr(A_CT, 32'h0);
        chk("R7 enable writable", 32'(pll_en), 0);
        wr(A_CT, EN | 32'h0001_0101);
        chk("R7 held dividers", {pll_m, pll_p, pll_s}, {9'd31, 6'd2, 3'd0});
        wait_lock(5, "R7 enable with guard clear");
        wr(A_GD, 32'h2);
    endtask

    task automatic t_disable;
        wr(A_LT, 32'd10);
        wr(A_CT, EN | 32'h001F_0201);
        cycles(3);
        wr(A_CT, 32'h001F_0201);
        chk("R9 disable drops lock", {pll_en, pll_locked}, 0);
        cycles(20);
        chk("R9 counter stopped", 32'(pll_locked), 0);
        wr(A_CT, EN | 32'h001F_0201);
        wait_lock(10, "R9 full count after re-enable");
    endtask

    task automatic t_ltime;
        logic early;
        early = 1'b0;
        wr(A_LT, 32'd6);
        wr(A_CT, EN | 32'h001F_0201);
        wr(A_LT, 32'd50);
        chk("R10 low after start", 32'(pll_locked), 0);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk);
            if (pll_locked) early = 1'b1;
        end
        chk("R10 no early lock", 32'(early), 0);
        cycles(1);
        chk("R10 captured count", 32'(pll_locked), 1);
        wr(A_LT, 32'd0);
        wr(A_FR, 32'h0000_0010);
        wait_lock(1, "R10 zero acts as one");
    endtask

    task automatic t_restart;
        wr(A_LT, 32'd8);
        wr(A_CT, EN | 32'h001F_0201);
        cycles(3);
        wr(A_CT, EN | 32'h001F_0201);
        wait_lock(8, "R12 reload on restart");
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R11 read 0x08", v, 0);
        rd(8'h14, v); chk("R11 read 0x14", v, 0);
        rd(8'h11, v); chk("R11 read unaligned", v, 0);
        rd(A_LT, v); chk("R11 lock time untouched", v, 32'd8);
        rd(A_GD, v); chk("R11 guard untouched", v, 32'h2);
        rd(A_CT, v); chk("R11 ctrl untouched", v, 32'hA01F_0201);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_regs();
        t_lock_seq();
        t_guard();
        t_disable();
        t_ltime();
        t_restart();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule